// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block takes a DDR3 SDRAM device from power-on to a state where normal traffic can begin. After its own reset is released, it holds the memory reset pin low and the clock enable low for the mandated times. It then raises clock enable, waits for the device to leave reset, and writes the four mode registers in a fixed order. A long ZQ calibration command follows, and once the calibration window has passed the block raises a done flag. Every command is driven onto a chip-select / RAS / CAS / WE / bank / address bus in the command-clock domain.

All waits are whole command-clock cycles. They are worked out at elaboration time from the command-clock frequency parameter (in kHz), so the same code fits any clock plan; the reference plan is a 200 MHz command clock for an 800 MT/s interface. A skip parameter shortens the two long power-up waits to a single cycle each, so that simulations do not spend hundreds of microseconds waiting. Every cycle that carries no command carries a NOP. A synchronous reset restarts the whole sequence.

Top module: `ddr3_init_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `mem_rst_n` and `mem_cke` are 0, `init_done` is 0 and the command bus holds NOP. Command code `{cs_n,ras_n,cas_n,we_n}` values: NOP = 0111, MRS = 0000, ZQCL = 0110.
- R2: With SKIP_PUP_WAIT = 0, `mem_rst_n` first reads 1 exactly T_RST = ceil(200 us x f) cycles after `rst` is released (f = CLK_KHZ).
- R3: With SKIP_PUP_WAIT = 0, `mem_cke` first reads 1 exactly T_CKE = ceil(500 us x f) cycles after `mem_rst_n` rises. `mem_cke` is never 1 while `mem_rst_n` is 0.
- R4: The first command after `mem_cke` rises is MRS to MR2 (`mem_ba` = 2), issued exactly T_XPR = max(5, ceil(360 ns x f)) cycles after the rise. Its address is 0: full-array self-refresh (A[2:0]=000), write latency 5 (A[5:3]=000), auto self-refresh off (A6=0), normal temperature range (A7=0), dynamic ODT off (A[10:9]=00).
- R5: MR3, MR1 and MR0 follow MR2 in that order, each exactly 4 cycles after the previous one. Their bank/address pairs are 3/0x000, 1/0x004 and 0/0x520.
- R6: ZQCL (`mem_ba` = 0, address 0x400, so A10 = 1) is issued exactly 12 cycles after the MR0 write.
- R7: `init_done` rises exactly 512 cycles after ZQCL and then stays high until the next reset.
- R8: Every cycle other than the five command cycles carries NOP, including every cycle after `init_done` rises. Exactly five non-NOP cycles occur per sequence.
- R9: Asserting `rst` at any point, whether in mid-sequence or after completion, drives `mem_rst_n`, `mem_cke` and `init_done` to 0 one cycle later. After release, the full sequence repeats with the same timing.
- R10: With SKIP_PUP_WAIT = 1, T_RST and T_CKE are each 1 cycle. All later intervals are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst | input | 1 | Synchronous active-high reset; restarts the sequence |
| mem_rst_n | output | 1 | Memory reset pin, active low |
| mem_cke | output | 1 | Memory clock enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | 3 | Bank address / mode register select |
| mem_addr | output | ROW_W | Address bus / mode register value |
| init_done | output | 1 | High once the device is ready |

## Verification
The bench builds two copies at CLK_KHZ = 1000. The first has SKIP_PUP_WAIT = 0, which makes the 200 us and 500 us waits 200 and 500 cycles. At that frequency the exact full-length sequence, with every interval, command and restart, fits in a short run. The second has SKIP_PUP_WAIT = 1 and shows that only the two long waits collapse. At this slow clock the 360 ns exit time rounds below its five-cycle floor, so the floor of that maximum is what gets exercised.

// File: rtl/ddr3i_pkg.sv
`timescale 1ns/1ps
package ddr3i_pkg;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } ctl_t;

    typedef enum logic [3:0] {
        PH_RESET    = 4'd0,
        PH_CKE_WAIT = 4'd1,
        PH_XPR      = 4'd2,
        PH_MR2      = 4'd3,
        PH_MR3      = 4'd4,
        PH_MR1      = 4'd5,
        PH_MR0      = 4'd6,
        PH_ZQ       = 4'd7,
        PH_DONE     = 4'd8
    } phase_e;

    localparam ctl_t CTL_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam ctl_t CTL_MRS  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
    localparam ctl_t CTL_ZQCL = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b0};

    // cycles covering a time span, rounded up
    function automatic int ns_to_cycles(longint span_ns, longint clk_khz);
        return int'((span_ns * clk_khz + 64'd999_999) / 64'd1_000_000);
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // mode register contents at the 800 MT/s operating point
    function automatic logic [15:0] mr_word(phase_e p);
        logic [15:0] w;
        w = '0;
        case (p)
            PH_MR2: w = '0;                 // full array, CWL 5, no ASR/SRT, no dyn ODT
            PH_MR3: w = '0;                 // MPR off
            PH_MR1: w[2] = 1'b1;            // DLL on, RZQ/6 drive, Rtt_nom RZQ/4
            PH_MR0: begin
                w[6:4]  = 3'b010;           // CAS latency 6
                w[8]    = 1'b1;             // DLL reset
                w[11:9] = 3'b010;           // write recovery 6
            end
            PH_ZQ:  w[10] = 1'b1;           // long calibration
            default: w = '0;
        endcase
        return w;
    endfunction

    function automatic logic [2:0] mr_bank(phase_e p);
        case (p)
            PH_MR2:  return 3'd2;
            PH_MR3:  return 3'd3;
            PH_MR1:  return 3'd1;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/ddr3i_timer.sv
`timescale 1ns/1ps
module ddr3i_timer #(
    parameter int CNT_W   = 8,
    parameter int RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    assign expired = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= CNT_W'(RST_VAL);
        else if (load)
            cnt_q <= load_val;
        else if (!expired)
            cnt_q <= cnt_q - CNT_W'(1);
    end
endmodule

// File: rtl/ddr3i_cmd_gen.sv
`timescale 1ns/1ps
module ddr3i_cmd_gen
    import ddr3i_pkg::*;
#(
    parameter int ROW_W = 14
) (
    input  phase_e           phase,
    input  logic             issue,
    output ctl_t             ctl,
    output logic [2:0]       ba,
    output logic [ROW_W-1:0] addr
);
    logic is_mr, is_zq;

    assign is_mr = (phase == PH_MR2) || (phase == PH_MR3) ||
                   (phase == PH_MR1) || (phase == PH_MR0);
    assign is_zq = (phase == PH_ZQ);

    always_comb begin
        ctl  = CTL_NOP;
        ba   = '0;
        addr = '0;
        if (issue && (is_mr || is_zq)) begin
            ctl  = is_zq ? CTL_ZQCL : CTL_MRS;
            ba   = mr_bank(phase);
            addr = ROW_W'(mr_word(phase));
        end
    end
endmodule

// File: rtl/ddr3_init_seq.sv
`timescale 1ns/1ps
module ddr3_init_seq
    import ddr3i_pkg::*;
#(
    parameter int CLK_KHZ       = 200_000,
    parameter int SKIP_PUP_WAIT = 0,
    parameter int ROW_W         = 14,
    parameter int T_RSTLOW_NS   = 200_000,
    parameter int T_CKEWAIT_NS  = 500_000,
    parameter int T_XPR_NS      = 360,
    parameter int T_XPR_MINCYC  = 5,
    parameter int T_MRD_CYC     = 4,
    parameter int T_MOD_CYC     = 12,
    parameter int T_ZQINIT_CYC  = 512
) (
    input  logic             clk,
    input  logic             rst,
    output logic             mem_rst_n,
    output logic             mem_cke,
    output logic             mem_cs_n,
    output logic             mem_ras_n,
    output logic             mem_cas_n,
    output logic             mem_we_n,
    output logic [2:0]       mem_ba,
    output logic [ROW_W-1:0] mem_addr,
    output logic             init_done
);
    localparam int RST_CYC = (SKIP_PUP_WAIT != 0) ? 1 :
                             max2(1, ns_to_cycles(T_RSTLOW_NS, CLK_KHZ));
    localparam int CKE_CYC = (SKIP_PUP_WAIT != 0) ? 1 :
                             max2(1, ns_to_cycles(T_CKEWAIT_NS, CLK_KHZ));
    localparam int XPR_CYC = max2(T_XPR_MINCYC, ns_to_cycles(T_XPR_NS, CLK_KHZ));
    localparam int MAXD    = max2(max2(RST_CYC, CKE_CYC),
                                  max2(max2(XPR_CYC, T_ZQINIT_CYC), max2(T_MRD_CYC, T_MOD_CYC)));
    localparam int CNT_W   = $clog2(MAXD) + 1;

    function automatic int dur_of(phase_e p);
        case (p)
            PH_RESET:                 return RST_CYC;
            PH_CKE_WAIT:              return CKE_CYC;
            PH_XPR:                   return XPR_CYC;
            PH_MR2, PH_MR3, PH_MR1:   return T_MRD_CYC;
            PH_MR0:                   return T_MOD_CYC;
            PH_ZQ:                    return T_ZQINIT_CYC;
            default:                  return 1;
        endcase
    endfunction

    phase_e           phase_q, phase_nxt;
    logic             issue_q;
    logic             expired, advance;
    logic [CNT_W-1:0] next_len;
    ctl_t             ctl;

    assign phase_nxt = phase_e'(phase_q + 4'd1);
    assign advance   = expired && (phase_q != PH_DONE);
    assign next_len  = CNT_W'(dur_of(phase_nxt) - 1);

    ddr3i_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (RST_CYC - 1)
    ) timer_i (
        .clk      (clk),
        .rst      (rst),
        .load     (advance),
        .load_val (next_len),
        .expired  (expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_RESET;
            issue_q <= 1'b0;
        end else begin
            issue_q <= advance;
            if (advance)
                phase_q <= phase_nxt;
        end
    end

    ddr3i_cmd_gen #(.ROW_W(ROW_W)) cmd_i (
        .phase (phase_q),
        .issue (issue_q),
        .ctl   (ctl),
        .ba    (mem_ba),
        .addr  (mem_addr)
    );

    assign mem_cs_n  = ctl.cs_n;
    assign mem_ras_n = ctl.ras_n;
    assign mem_cas_n = ctl.cas_n;
    assign mem_we_n  = ctl.we_n;
    assign mem_rst_n = (phase_q != PH_RESET);
    assign mem_cke   = (phase_q >= PH_XPR);
    assign init_done = (phase_q == PH_DONE);
endmodule

// File: rtl/ddr3i_chk.sv
`timescale 1ns/1ps
module ddr3i_chk
    import ddr3i_pkg::*;
#(
    parameter int CLK_KHZ       = 200_000,
    parameter int SKIP_PUP_WAIT = 0,
    parameter int T_RSTLOW_NS   = 200_000,
    parameter int T_CKEWAIT_NS  = 500_000
) (
    input logic clk,
    input logic rst,
    input logic mem_rst_n,
    input logic mem_cke,
    input logic mem_cs_n,
    input logic mem_ras_n,
    input logic mem_cas_n,
    input logic mem_we_n,
    input logic init_done
);
    localparam int LOW_MIN  = (SKIP_PUP_WAIT != 0) ? 1 : ns_to_cycles(T_RSTLOW_NS, CLK_KHZ);
    localparam int WAIT_MIN = (SKIP_PUP_WAIT != 0) ? 1 : ns_to_cycles(T_CKEWAIT_NS, CLK_KHZ);

    logic [3:0] code;
    logic       is_mrs, is_nop;
    int         low_cnt, wait_cnt;

    assign code   = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
    assign is_mrs = (code == 4'b0000);
    assign is_nop = (code == 4'b0111);

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt  <= 0;
            wait_cnt <= 0;
        end else begin
            if (!mem_rst_n && low_cnt < LOW_MIN + 1)
                low_cnt <= low_cnt + 1;
            if (mem_rst_n && !mem_cke && wait_cnt < WAIT_MIN + 1)
                wait_cnt <= wait_cnt + 1;
        end
    end

    p_rst_low_time_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_rst_n) |-> (low_cnt >= LOW_MIN));

    p_cke_wait_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_cke) |-> (wait_cnt >= WAIT_MIN));

    p_cke_order_r3: assert property (@(posedge clk) disable iff (rst)
        !mem_rst_n |-> !mem_cke);

    p_mrs_gap_r5: assert property (@(posedge clk) disable iff (rst)
        is_mrs |-> (!$past(is_mrs) && !$past(is_mrs, 2) && !$past(is_mrs, 3)));

    p_done_hold_r7: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
        init_done |-> is_nop);
endmodule

bind ddr3_init_seq ddr3i_chk #(
    .CLK_KHZ       (CLK_KHZ),
    .SKIP_PUP_WAIT (SKIP_PUP_WAIT),
    .T_RSTLOW_NS   (T_RSTLOW_NS),
    .T_CKEWAIT_NS  (T_CKEWAIT_NS)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .mem_rst_n (mem_rst_n),
    .mem_cke   (mem_cke),
    .mem_cs_n  (mem_cs_n),
    .mem_ras_n (mem_ras_n),
    .mem_cas_n (mem_cas_n),
    .mem_we_n  (mem_we_n),
    .init_done (init_done)
);

// File: tb/ddr3_init_seq_tb_top.sv
`timescale 1ns/1ps
module ddr3_init_seq_tb_top;
    localparam int KHZ   = 1000;
    localparam int ROW_W = 14;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;   // 125 MHz

    logic             a_rn, a_ck, a_cs, a_ras, a_cas, a_we, a_dn;
    logic [2:0]       a_ba;
    logic [ROW_W-1:0] a_ad;
    logic             b_rn, b_ck, b_cs, b_ras, b_cas, b_we, b_dn;
    logic [2:0]       b_ba;
    logic [ROW_W-1:0] b_ad;

    ddr3_init_seq #(.CLK_KHZ(KHZ), .SKIP_PUP_WAIT(0), .ROW_W(ROW_W)) dut_i (
        .clk(clk), .rst(rst), .mem_rst_n(a_rn), .mem_cke(a_ck), .mem_cs_n(a_cs),
        .mem_ras_n(a_ras), .mem_cas_n(a_cas), .mem_we_n(a_we), .mem_ba(a_ba),
        .mem_addr(a_ad), .init_done(a_dn));

    ddr3_init_seq #(.CLK_KHZ(KHZ), .SKIP_PUP_WAIT(1), .ROW_W(ROW_W)) dut_skip_i (
        .clk(clk), .rst(rst), .mem_rst_n(b_rn), .mem_cke(b_ck), .mem_cs_n(b_cs),
        .mem_ras_n(b_ras), .mem_cas_n(b_cas), .mem_we_n(b_we), .mem_ba(b_ba),
        .mem_addr(b_ad), .init_done(b_dn));

    int mon_sel = 0;
    logic             m_rn, m_ck, m_dn;
    logic [3:0]       m_code;
    logic [2:0]       m_ba;
    logic [ROW_W-1:0] m_ad;
    assign m_rn   = mon_sel ? b_rn : a_rn;
    assign m_ck   = mon_sel ? b_ck : a_ck;
    assign m_dn   = mon_sel ? b_dn : a_dn;
    assign m_code = mon_sel ? {b_cs, b_ras, b_cas, b_we} : {a_cs, a_ras, a_cas, a_we};
    assign m_ba   = mon_sel ? b_ba : a_ba;
    assign m_ad   = mon_sel ? b_ad : a_ad;

    localparam logic [3:0] C_NOP = 4'b0111, C_MRS = 4'b0000, C_ZQ = 4'b0110;

    int checks = 0;
    int failures = 0;

    int k_rn, k_ck, k_dn, n_ev, order_bad, done_drop;
    int         ev_k[8];
    logic [3:0] ev_code[8];
    logic [2:0] ev_ba[8];
    int         ev_ad[8];

    function automatic int cdiv(longint a, longint b);
        return int'((a + b - 1) / b);
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
    endtask

    // samples once per cycle, k = posedges since reset release
    task automatic observe(input int stop_k);
        n_ev = 0; k_rn = -1; k_ck = -1; k_dn = -1; order_bad = 0; done_drop = 0;
        for (int k = 0; k <= stop_k; k++) begin
            if (k > 0) @(negedge clk);
            if (m_rn && k_rn < 0) k_rn = k;
            if (m_ck && k_ck < 0) k_ck = k;
            if (m_ck && !m_rn) order_bad++;
            if (k_dn >= 0 && !m_dn) done_drop++;
            if (m_dn && k_dn < 0) k_dn = k;
            if (m_code != C_NOP) begin
                if (n_ev < 8) begin
                    ev_k[n_ev] = k; ev_code[n_ev] = m_code;
                    ev_ba[n_ev] = m_ba; ev_ad[n_ev] = int'(m_ad);
                end
                n_ev++;
            end
        end
    endtask

    task automatic check_timeline(input int skip, input string tag);
        int t_rst, t_cke, t_xpr, base;
        t_rst = skip ? 1 : cdiv(64'd200_000 * KHZ, 64'd1_000_000);
        t_cke = skip ? 1 : cdiv(64'd500_000 * KHZ, 64'd1_000_000);
        t_xpr = cdiv(64'd360 * KHZ, 64'd1_000_000);
        if (t_xpr < 5) t_xpr = 5;
        chk(skip ? "R10" : "R2", {tag, " rst_n release cycle"}, k_rn, t_rst);
        chk(skip ? "R10" : "R3", {tag, " cke rise cycle"}, k_ck, t_rst + t_cke);
        chk("R3", {tag, " cke high with rst_n low"}, order_bad, 0);
        chk("R8", {tag, " non-NOP count"}, n_ev, 5);
        base = t_rst + t_cke + t_xpr;
        chk("R4", {tag, " MR2 cycle"}, ev_k[0], base);
        chk("R4", {tag, " MR2 code"}, ev_code[0], C_MRS);
        chk("R4", {tag, " MR2 bank"}, ev_ba[0], 2);
        chk("R4", {tag, " MR2 addr"}, ev_ad[0], 0);
        chk("R5", {tag, " MR3 cycle"}, ev_k[1], base + 4);
        chk("R5", {tag, " MR3 code/bank/addr"}, {ev_code[1], ev_ba[1], ev_ad[1][11:0]}, {C_MRS, 3'd3, 12'h000});
        chk("R5", {tag, " MR1 cycle"}, ev_k[2], base + 8);
        chk("R5", {tag, " MR1 code/bank/addr"}, {ev_code[2], ev_ba[2], ev_ad[2][11:0]}, {C_MRS, 3'd1, 12'h004});
        chk("R5", {tag, " MR0 cycle"}, ev_k[3], base + 12);
        chk("R5", {tag, " MR0 code/bank/addr"}, {ev_code[3], ev_ba[3], ev_ad[3][11:0]}, {C_MRS, 3'd0, 12'h520});
        chk("R6", {tag, " ZQCL cycle"}, ev_k[4], base + 24);
        chk("R6", {tag, " ZQCL code/bank/addr"}, {ev_code[4], ev_ba[4], ev_ad[4][11:0]}, {C_ZQ, 3'd0, 12'h400});
        chk("R7", {tag, " done cycle"}, k_dn, base + 24 + 512);
        chk("R7", {tag, " done dropped"}, done_drop, 0);
    endtask

    task automatic test_reset_state();
        mon_sel = 0;
        @(negedge clk); rst = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1", "rst_n in reset", m_rn, 0);
        chk("R1", "cke in reset", m_ck, 0);
        chk("R1", "done in reset", m_dn, 0);
        chk("R1", "cmd in reset", m_code, C_NOP);
        rst = 1'b0;
        chk("R1", "rst_n first cycle after reset", m_rn, 0);
        chk("R1", "cke first cycle after reset", m_ck, 0);
    endtask

    task automatic test_full_sequence();
        mon_sel = 0;
        apply_reset();
        observe(200 + 500 + 5 + 24 + 512 + 30);
        check_timeline(0, "full");
        // reset after completion clears done
        rst = 1'b1;
        @(negedge clk);
        chk("R9", "done after late reset", m_dn, 0);
        chk("R9", "rst_n after late reset", m_rn, 0);
        rst = 1'b0;
    endtask

    task automatic test_restart_mid();
        mon_sel = 0;
        apply_reset();
        observe(715);
        chk("R9", "pre-restart MRS count", n_ev, 3);
        rst = 1'b1;
        @(negedge clk);
        chk("R9", "rst_n after mid reset", m_rn, 0);
        chk("R9", "cke after mid reset", m_ck, 0);
        chk("R9", "done after mid reset", m_dn, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        observe(200 + 500 + 5 + 24 + 512 + 10);
        check_timeline(0, "restart");
    endtask

    task automatic test_skip();
        mon_sel = 1;
        apply_reset();
        observe(1 + 1 + 5 + 24 + 512 + 20);
        check_timeline(1, "skip");
    endtask

    initial begin
        repeat (150_000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        test_reset_state();
        test_full_sequence();
        test_restart_mid();
        test_skip();
        summary();
        $finish;
    end
endmodule